// File: doc/BRIEF.md
# External Interrupt Request Flag Unit

This block keeps the pending request flags for five external interrupt channels of a small microcontroller interrupt controller. It numbers them 2 to 6. Each pin first passes through a synchronizer. It then goes to an edge detector, whose one-cycle pulse sets a sticky pending flag.

Channels 2 and 3 trigger on the edge chosen by a two-bit polarity register that software can write. Channels 4, 5 and 6 trigger only on rising edges. A compare-match pulse from a timer capture/compare unit can also set channels 3 to 6. This works whatever level the pin has.

A flag clears when the CPU acknowledges that channel through a one-hot strobe. Software can also load all five flags directly. A hardware set in the same cycle always takes precedence over any clear. Priority resolution, vectoring and the timer are outside this block.

Top module: `ext_irq_flags`

## Requirements
- R1: After synchronous reset, all five pending flags read 0 and both polarity bits read 0, so channels 2 and 3 start in falling-edge mode.
- R2: Channel 2 (pending bit 0) sets on a falling pin edge when polarity bit 0 is 0, and on a rising edge when it is 1. The edge is on pin bit 0. A new pin level first sampled at clock edge n raises the flag after edge n+2.
- R3: Channel 3 (pending bit 1) behaves the same way, using pin bit 1 and polarity bit 1 (0 = falling, 1 = rising).
- R4: Channels 4 to 6 (pending bits 2 to 4, pins 2 to 4) set only on a rising pin edge. A falling edge on those pins leaves their flags at 0.
- R5: A one-cycle compare pulse on cmp_evt bit k sets pending bit k+1 at the next clock edge, whatever the pin level. The pulse sets channels 3 to 6 only.
- R6: An acknowledge strobe on ack bit i clears pending bit i at the next clock edge. At most one acknowledge bit is high in any cycle.
- R7: If an edge or compare event sets a flag in the same cycle that flag is acknowledged, the flag stays set.
- R8: When flag_wr_en is high, the flags load flag_wr_data at the next edge. Any flag that a hardware event sets in that cycle still reads 1.
- R9: Writing the polarity register while the pins hold steady does not set any flag.
- R10: When pol_wr_en is high, the polarity register loads pol_wr_val at the next edge and shows it on pol.
- R11: With no edge, compare pulse, acknowledge or software write, every flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 5 | Asynchronous pins, bit 0 = channel 2 ... bit 4 = channel 6 |
| cmp_evt | input | 4 | Compare-match pulses, bit 0 = channel 3 ... bit 3 = channel 6 |
| ack | input | 5 | One-hot vector acknowledge, same order as pending |
| flag_wr_en | input | 1 | Software flag write strobe |
| flag_wr_data | input | 5 | Value loaded into the flags |
| pol_wr_en | input | 1 | Polarity register write strobe |
| pol_wr_val | input | 2 | New polarity, bit 0 = channel 2, bit 1 = channel 3, 1 = rising |
| pol | output | 2 | Polarity register readback |
| pending | output | 5 | Registered pending flags, bit 0 = channel 2 ... bit 4 = channel 6 |

## Verification
The bench builds the block with its default two-stage synchronizer. With that depth the pin-to-flag latency is three edges, and the reference model reproduces it exactly with a sample queue. The fixed channel map lets every channel be driven on its own. Directed phases then collide acknowledges, software writes and compare pulses with edges in the same cycle. A long random phase follows, compared with the model on every clock.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int N_CH      = 5;  // channels 2..6
  localparam int N_SEL     = 2;  // channels with selectable polarity (lowest indices)
  localparam int CMP_BASE  = 1;  // first channel that takes a compare pulse
  localparam int N_CMP     = N_CH - CMP_BASE;
  typedef enum logic { EDGE_FALL = 1'b0, EDGE_RISE = 1'b1 } edge_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else begin
      chain[0] <= d_async;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det
  import irq_flag_pkg::*;
#(
  parameter int WIDTH = 5,
  parameter int NSEL  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [NSEL-1:0]  pol,
  output logic [WIDTH-1:0] pulse
);
  // previous raw level; polarity is applied after the compare
  logic [WIDTH-1:0] prev_lvl;
  logic [WIDTH-1:0] rise, fall;

  always_ff @(posedge clk) begin
    if (rst) prev_lvl <= '0;
    else     prev_lvl <= level;
  end

  assign rise = level & ~prev_lvl;
  assign fall = ~level & prev_lvl;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ch
    if (i < NSEL) begin : g_sel
      assign pulse[i] = (edge_sel_e'(pol[i]) == EDGE_RISE) ? rise[i] : fall[i];
    end else begin : g_fixed
      assign pulse[i] = rise[i];
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] hw_set,
  input  logic [WIDTH-1:0] ack,
  input  logic             sw_en,
  input  logic [WIDTH-1:0] sw_data,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] kept;

  always_comb begin
    if (sw_en) kept = sw_data;
    else       kept = flags & ~ack;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= hw_set | kept;
  end
endmodule

// File: rtl/ext_irq_flags.sv
module ext_irq_flags
  import irq_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_CH-1:0]  irq_pin,
  input  logic [N_CMP-1:0] cmp_evt,
  input  logic [N_CH-1:0]  ack,
  input  logic             flag_wr_en,
  input  logic [N_CH-1:0]  flag_wr_data,
  input  logic             pol_wr_en,
  input  logic [N_SEL-1:0] pol_wr_val,
  output logic [N_SEL-1:0] pol,
  output logic [N_CH-1:0]  pending
);
  logic [N_CH-1:0] pin_s;
  logic [N_CH-1:0] edge_pulse;
  logic [N_CH-1:0] cmp_vec;
  logic [N_CH-1:0] hw_set;

  always_ff @(posedge clk) begin
    if (rst)            pol <= '0;
    else if (pol_wr_en) pol <= pol_wr_val;
  end

  irq_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(irq_pin), .q_sync(pin_s)
  );

  irq_edge_det #(.WIDTH(N_CH), .NSEL(N_SEL)) u_edge (
    .clk(clk), .rst(rst), .level(pin_s), .pol(pol), .pulse(edge_pulse)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_cmp
    if (i >= CMP_BASE) begin : g_on
      assign cmp_vec[i] = cmp_evt[i-CMP_BASE];
    end else begin : g_off
      assign cmp_vec[i] = 1'b0;
    end
  end

  assign hw_set = edge_pulse | cmp_vec;

  irq_flag_bank #(.WIDTH(N_CH)) u_bank (
    .clk(clk), .rst(rst), .hw_set(hw_set), .ack(ack),
    .sw_en(flag_wr_en), .sw_data(flag_wr_data), .flags(pending)
  );
endmodule

// File: rtl/ext_irq_flags_chk.sv
module ext_irq_flags_chk
  import irq_flag_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [N_CMP-1:0] cmp_evt,
  input logic [N_CH-1:0]  ack,
  input logic             flag_wr_en,
  input logic [N_CH-1:0]  flag_wr_data,
  input logic             pol_wr_en,
  input logic [N_SEL-1:0] pol_wr_val,
  input logic [N_SEL-1:0] pol,
  input logic [N_CH-1:0]  pending,
  input logic [N_CH-1:0]  hw_set
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pending == '0 && pol == '0)); // R1

  AST_CMP_SETS: assert property (@(posedge clk) disable iff (rst)
    (cmp_evt != '0) |=> ((pending[N_CH-1:CMP_BASE] & $past(cmp_evt)) == $past(cmp_evt))); // R5

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!flag_wr_en && (ack & ~hw_set) != '0) |=> ((pending & $past(ack & ~hw_set)) == '0)); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hw_set != '0) |=> ((pending & $past(hw_set)) == $past(hw_set))); // R7

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
    flag_wr_en |=> (pending == ($past(flag_wr_data) | $past(hw_set)))); // R8

  AST_POL_WRITE: assert property (@(posedge clk) disable iff (rst)
    pol_wr_en |=> (pol == $past(pol_wr_val))); // R10

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hw_set == '0 && ack == '0 && !flag_wr_en) |=> $stable(pending)); // R11
endmodule

bind ext_irq_flags ext_irq_flags_chk u_chk (
  .clk(clk), .rst(rst), .cmp_evt(cmp_evt), .ack(ack),
  .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
  .pol_wr_en(pol_wr_en), .pol_wr_val(pol_wr_val),
  .pol(pol), .pending(pending), .hw_set(hw_set)
);

// File: tb/tb_ext_irq_flags.sv
module tb_ext_irq_flags;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] irq_pin = '0;
  logic [3:0] cmp_evt = '0;
  logic [4:0] ack = '0;
  logic       flag_wr_en = 1'b0;
  logic [4:0] flag_wr_data = '0;
  logic       pol_wr_en = 1'b0;
  logic [1:0] pol_wr_val = '0;
  logic [1:0] pol;
  logic [4:0] pending;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R1";

  ext_irq_flags dut (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .cmp_evt(cmp_evt), .ack(ack),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .pol_wr_en(pol_wr_en), .pol_wr_val(pol_wr_val), .pol(pol), .pending(pending)
  );

  always #10 clk = ~clk; // 50 MHz

  // behavioural reference
  logic [4:0] q[$];
  logic [4:0] m_pend = '0;
  logic [1:0] m_pol = '0;

  always @(posedge clk) begin
    logic [4:0] s, p, det, hw;
    if (rst) begin
      m_pend = '0; m_pol = '0;
      q = {5'b0, 5'b0, 5'b0};
    end else begin
      q.push_back(irq_pin);
      s = q[1]; p = q[0];
      void'(q.pop_front());
      for (int c = 0; c < 5; c++) begin
        if (c < 2 && m_pol[c] == 1'b0) det[c] = ~s[c] & p[c];
        else                           det[c] = s[c] & ~p[c];
      end
      hw = det | {cmp_evt, 1'b0};
      m_pend = hw | (flag_wr_en ? flag_wr_data : (m_pend & ~ack));
      if (pol_wr_en) m_pol = pol_wr_val;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock; compare with model away from the edge; drop one-cycle strobes
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check(pending == m_pend, tag, pending, m_pend);
    check(pol == m_pol, "R10", pol, m_pol);
    ack = '0; cmp_evt = '0; flag_wr_en = 1'b0; pol_wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic sw_clear();
    flag_wr_en = 1'b1; flag_wr_data = '0; tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset values
    check(pending == 5'h00, "R1", pending, 0);
    check(pol == 2'b00, "R1", pol, 0);

    // R2: rising ignored while falling selected, then falling sets after 3 edges
    tag = "R2";
    irq_pin[0] = 1'b1; ticks(5);
    check(pending[0] == 1'b0, "R2", pending, 0);
    irq_pin[0] = 1'b0; ticks(2);
    check(pending[0] == 1'b0, "R2", pending, 0);
    tick();
    check(pending[0] == 1'b1, "R2", pending, 1);

    // R6: acknowledge clears
    tag = "R6";
    ack = 5'b00001; tick();
    check(pending == 5'h00, "R6", pending, 0);

    // R9: pins high and steady, flip polarity -> no flag
    tag = "R9";
    irq_pin[1:0] = 2'b11; ticks(5);
    pol_wr_en = 1'b1; pol_wr_val = 2'b11; tick();
    check(pol == 2'b11, "R10", pol, 3);
    ticks(4);
    check(pending == 5'h00, "R9", pending, 0);
    pol_wr_en = 1'b1; pol_wr_val = 2'b00; ticks(4);
    check(pending == 5'h00, "R9", pending, 0);

    // R3: channel 3 falling, then rising mode
    tag = "R3";
    irq_pin[1] = 1'b0; ticks(4);
    check(pending == 5'b00010, "R3", pending, 2);
    sw_clear();
    pol_wr_en = 1'b1; pol_wr_val = 2'b10; tick();
    irq_pin[1] = 1'b1; ticks(4);
    check(pending == 5'b00010, "R3", pending, 2);
    sw_clear();
    irq_pin[1] = 1'b0; ticks(4);
    check(pending == 5'h00, "R3", pending, 0);

    // R2 rising mode
    tag = "R2";
    irq_pin[0] = 1'b0; ticks(4);
    sw_clear();
    pol_wr_en = 1'b1; pol_wr_val = 2'b01; tick();
    irq_pin[0] = 1'b1; ticks(4);
    check(pending == 5'b00001, "R2", pending, 1);
    sw_clear();

    // R4: fixed rising channels
    tag = "R4";
    irq_pin[4:2] = 3'b111; ticks(4);
    check(pending == 5'b11100, "R4", pending, 5'h1c);
    sw_clear();
    irq_pin[4:2] = 3'b000; ticks(5);
    check(pending == 5'h00, "R4", pending, 0);

    // R5: compare pulses set channels 3..6 regardless of pins
    tag = "R5";
    for (int k = 0; k < 4; k++) begin
      cmp_evt = 4'(1 << k); tick();
      check(pending == 5'(2 << k), "R5", pending, 2 << k);
      sw_clear();
    end

    // R7: set and acknowledge in the same cycle
    tag = "R7";
    flag_wr_en = 1'b1; flag_wr_data = 5'b01000; tick();
    ack = 5'b01000; cmp_evt = 4'b0100; tick();
    check(pending[3] == 1'b1, "R7", pending, 5'h08);

    // R8: software load, and hardware set beats software clear
    tag = "R8";
    flag_wr_en = 1'b1; flag_wr_data = 5'b10101; tick();
    check(pending == 5'b10101, "R8", pending, 5'h15);
    flag_wr_en = 1'b1; flag_wr_data = 5'b00000; cmp_evt = 4'b1000; tick();
    check(pending == 5'b10000, "R8", pending, 5'h10);

    // R11: quiet cycles keep flags
    tag = "R11";
    ticks(6);
    check(pending == 5'b10000, "R11", pending, 5'h10);

    // random mix
    tag = "R2/R3/R4/R5/R6/R7/R8/R11";
    for (int n = 0; n < 2000; n++) begin
      if ($urandom % 6 == 0) irq_pin = 5'($urandom);
      if ($urandom % 5 == 0) cmp_evt = 4'($urandom);
      if ($urandom % 3 == 0) ack = 5'(1 << ($urandom % 5));
      if ($urandom % 12 == 0) begin flag_wr_en = 1'b1; flag_wr_data = 5'($urandom); end
      if ($urandom % 20 == 0) begin pol_wr_en = 1'b1; pol_wr_val = 2'($urandom); end
      tick();
    end

    finish_run();
  end
endmodule